// File: doc/BRIEF.md
# Banked CPU Register File

This block holds the architectural register state of a 32-bit processor core: sixteen general registers, where the low eight have a second physical copy, a thirty-two entry floating-point store split into a live half and an extended half, the packed status word with its condition flags, and the floating-point control word. The execute stage reads two general registers at once and writes one per cycle. The floating-point unit has its own read and write port. A debug port can reach either copy of the low eight registers, whichever copy is live at the time.

The status register decides which copy of the low eight registers is live. The alternate copy is live only when the privileged-mode bit and the bank bit are both set. When a status write changes that selection, the two copies trade places, so the values that were live become the shadow copy and the other way round. The four condition flags T, S, M and Q are kept as separate flip-flops so that an ALU can update them without rewriting the status word. A status read merges them back into their bit positions. In the floating-point control word, flipping the bank bit trades the sixteen live floating-point registers with the sixteen extended ones.

Top module: `bank_regfile`

## Requirements
- R1: After reset, every general and floating-point register reads zero, the status register reads 0x700000F0 and the floating-point control register reads 0x00040001.
- R2: The effective integer bank is status bit 30 AND status bit 29. Indices 0 to 7 on the read ports and the write port reach the live copy of R0 to R7. Indices 8 to 15 reach one shared set that no bank change affects. Reads are combinational, and a write shows from the next cycle.
- R3: A status write swaps live and shadow R0 to R7 only when the effective bank of the written value differs from the current one. A write that keeps the selection leaves every register value in place.
- R4: A status write stores the value ANDed with 0x700083F3, and it loads T, S, Q and M from bits 0, 1, 8 and 9 of the written value.
- R5: A status read returns the stored word with bits 0, 1, 8 and 9 replaced by the live T, S, Q and M flags. The flag port (bit0=T, bit1=S, bit2=Q, bit3=M) updates only the flags. In a cycle with a status write as well, the status write wins.
- R6: A floating-point control write stores the value ANDed with 0x003FFFFF. When bit 21 changes, the sixteen live floating-point registers trade with the sixteen extended ones. A floating-point write in the same cycle lands in the live set as it stands after the trade.
- R7: Floating-point read indices 0 to 15 return the live registers, and indices 16 to 31 return the extended registers 0 to 15.
- R8: Debug indices 0 to 7 return bank-0 R0 to R7 and indices 8 to 15 return bank-1 R0 to R7. When bank 0 is live these are the live registers, otherwise they are the shadow copies, and the reverse holds for bank 1. A bank swap never changes what a debug index returns.
- R9: A general-register write to index 0 to 7 in the same cycle as a status write that changes the bank lands in the bank that is live after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised on release |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General-register write enable |
| wr_idx | input | 4 | General-register write index |
| wr_data | input | 32 | General-register write data |
| flag_we | input | 1 | Condition-flag update enable |
| flag_wdata | input | 4 | New flags: bit0 T, bit1 S, bit2 Q, bit3 M |
| sr_we | input | 1 | Status-register write enable |
| sr_wdata | input | 32 | Status-register write value |
| sr_rdata | output | 32 | Status register with flags merged in |
| fpscr_we | input | 1 | Floating-point control write enable |
| fpscr_wdata | input | 32 | Floating-point control write value |
| fpscr_rdata | output | 32 | Floating-point control register |
| fp_we | input | 1 | Floating-point register write enable |
| fp_wr_idx | input | 4 | Live floating-point register to write |
| fp_wdata | input | 32 | Floating-point write data |
| fp_rd_idx | input | 5 | Floating-point read index (16 and up: extended) |
| fp_rd_data | output | 32 | Floating-point read data |
| dbg_idx | input | 4 | Debug index (0-7 bank 0, 8-15 bank 1) |
| dbg_rdata | output | 32 | Debug read data |

## Verification
Two sets of events can fall in one cycle. A general-register write can coincide with a status write that changes the integer bank, and a floating-point write can coincide with a control write that flips the floating-point bank. The bench forces both pairs in directed steps. It then checks that the written value appears at the same index on the live read port, and at the debug index of the newly live bank, while the other bank is left unchanged. Random traffic produces the same pairings again, together with flag updates that race status writes, and every output is compared each cycle against a bench model that really copies registers between live and shadow arrays.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int unsigned SR_MD_BIT  = 30;
  localparam int unsigned SR_RB_BIT  = 29;
  localparam int unsigned SR_M_BIT   = 9;
  localparam int unsigned SR_Q_BIT   = 8;
  localparam int unsigned SR_S_BIT   = 1;
  localparam int unsigned SR_T_BIT   = 0;
  localparam int unsigned FP_BANK_BIT = 21;

  localparam logic [31:0] SR_WMASK    = 32'h7000_83F3;
  localparam logic [31:0] SR_FLAGPOS  = 32'h0000_0303;
  localparam logic [31:0] SR_RESET    = 32'h7000_00F0;
  localparam logic [31:0] FPC_WMASK   = 32'h003F_FFFF;
  localparam logic [31:0] FPC_RESET   = 32'h0004_0001;

  typedef struct packed {
    logic m;
    logic q;
    logic s;
    logic t;
  } cflags_t;

  function automatic cflags_t flags_of(input logic [31:0] w);
    cflags_t f;
    f.m = w[SR_M_BIT];
    f.q = w[SR_Q_BIT];
    f.s = w[SR_S_BIT];
    f.t = w[SR_T_BIT];
    return f;
  endfunction

  function automatic logic [31:0] flags_word(input cflags_t f);
    logic [31:0] w;
    w = '0;
    w[SR_M_BIT] = f.m;
    w[SR_Q_BIT] = f.q;
    w[SR_S_BIT] = f.s;
    w[SR_T_BIT] = f.t;
    return w;
  endfunction

  function automatic logic eff_bank(input logic [31:0] w);
    return w[SR_MD_BIT] & w[SR_RB_BIT];
  endfunction
endpackage

// File: rtl/brf_ctrl.sv
module brf_ctrl
  import brf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sr_we,
  input  logic [31:0] sr_wdata,
  input  logic        flag_we,
  input  logic [3:0]  flag_wdata,
  input  logic        fpscr_we,
  input  logic [31:0] fpscr_wdata,
  output logic [31:0] sr_rdata,
  output logic [31:0] fpscr_rdata,
  output logic        int_bank_q,
  output logic        int_bank_d,
  output logic        fp_bank_q,
  output logic        fp_bank_d
);
  logic [31:0] srw_q, srw_d;
  cflags_t     flg_q, flg_d;
  logic [31:0] fpc_q, fpc_d;

  always_comb begin
    srw_d = srw_q;
    flg_d = flg_q;
    fpc_d = fpc_q;
    if (sr_we) begin
      srw_d = sr_wdata & SR_WMASK & ~SR_FLAGPOS;
      flg_d = flags_of(sr_wdata);
    end else if (flag_we) begin
      flg_d = cflags_t'(flag_wdata);
    end
    if (fpscr_we) begin
      fpc_d = fpscr_wdata & FPC_WMASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srw_q <= SR_RESET & ~SR_FLAGPOS;
      flg_q <= flags_of(SR_RESET);
      fpc_q <= FPC_RESET;
    end else begin
      srw_q <= srw_d;
      flg_q <= flg_d;
      fpc_q <= fpc_d;
    end
  end

  assign sr_rdata    = srw_q | flags_word(flg_q);
  assign fpscr_rdata = fpc_q;
  assign int_bank_q  = eff_bank(srw_q);
  assign int_bank_d  = eff_bank(srw_d);
  assign fp_bank_q   = fpc_q[FP_BANK_BIT];
  assign fp_bank_d   = fpc_d[FP_BANK_BIT];
endmodule

// File: rtl/brf_int_bank.sv
module brf_int_bank #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NGPR    = 16,
  parameter int unsigned NBANKED = 8,
  localparam int unsigned IDXW   = $clog2(NGPR),
  localparam int unsigned BIDXW  = $clog2(NBANKED),
  localparam int unsigned NSHARE = NGPR - NBANKED,
  localparam int unsigned SIDXW  = (NSHARE > 1) ? $clog2(NSHARE) : 1,
  localparam int unsigned DIDXW  = BIDXW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_q,
  input  logic             bank_d,
  input  logic [IDXW-1:0]  rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [IDXW-1:0]  rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [DIDXW-1:0] dbg_idx,
  output logic [XLEN-1:0]  dbg_rdata
);
  logic [XLEN-1:0] lo_q [2][NBANKED];
  logic [XLEN-1:0] lo_d [2][NBANKED];
  logic [XLEN-1:0] sh_q [NSHARE];
  logic [XLEN-1:0] sh_d [NSHARE];

  function automatic logic [SIDXW-1:0] sh_off(input logic [IDXW-1:0] i);
    logic [IDXW-1:0] o;
    o = i - IDXW'(NBANKED);
    return o[SIDXW-1:0];
  endfunction

  function automatic logic [XLEN-1:0] rd_live(input logic [IDXW-1:0] i);
    if (i < IDXW'(NBANKED)) return lo_q[bank_q][i[BIDXW-1:0]];
    else                    return sh_q[sh_off(i)];
  endfunction

  always_comb begin
    lo_d = lo_q;
    sh_d = sh_q;
    if (wr_en) begin
      if (wr_idx < IDXW'(NBANKED)) lo_d[bank_d][wr_idx[BIDXW-1:0]] = wr_data;
      else                         sh_d[sh_off(wr_idx)] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NBANKED; i++) lo_q[b][i] <= '0;
      for (int i = 0; i < NSHARE; i++) sh_q[i] <= '0;
    end else if (wr_en) begin
      lo_q <= lo_d;
      sh_q <= sh_d;
    end
  end

  assign rd_a_data = rd_live(rd_a_idx);
  assign rd_b_data = rd_live(rd_b_idx);
  assign dbg_rdata = lo_q[dbg_idx[DIDXW-1]][dbg_idx[BIDXW-1:0]];
endmodule

// File: rtl/brf_fp_bank.sv
module brf_fp_bank #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NFPR  = 16,
  localparam int unsigned FIDXW = $clog2(NFPR),
  localparam int unsigned RIDXW = FIDXW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_q,
  input  logic             bank_d,
  input  logic             fp_we,
  input  logic [FIDXW-1:0] fp_wr_idx,
  input  logic [XLEN-1:0]  fp_wdata,
  input  logic [RIDXW-1:0] fp_rd_idx,
  output logic [XLEN-1:0]  fp_rd_data
);
  logic [XLEN-1:0] fr_q [2][NFPR];
  logic [XLEN-1:0] fr_d [2][NFPR];
  logic            rd_phys;

  always_comb begin
    fr_d = fr_q;
    if (fp_we) fr_d[bank_d][fp_wr_idx] = fp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NFPR; i++) fr_q[b][i] <= '0;
    end else if (fp_we) begin
      fr_q <= fr_d;
    end
  end

  assign rd_phys    = bank_q ^ fp_rd_idx[RIDXW-1];
  assign fp_rd_data = fr_q[rd_phys][fp_rd_idx[FIDXW-1:0]];
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NGPR    = 16,
  parameter int unsigned NBANKED = 8,
  parameter int unsigned NFPR    = 16,
  localparam int unsigned IDXW   = $clog2(NGPR),
  localparam int unsigned DIDXW  = $clog2(NBANKED) + 1,
  localparam int unsigned FIDXW  = $clog2(NFPR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDXW-1:0]  rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [IDXW-1:0]  rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             flag_we,
  input  logic [3:0]       flag_wdata,
  input  logic             sr_we,
  input  logic [31:0]      sr_wdata,
  output logic [31:0]      sr_rdata,
  input  logic             fpscr_we,
  input  logic [31:0]      fpscr_wdata,
  output logic [31:0]      fpscr_rdata,
  input  logic             fp_we,
  input  logic [FIDXW-1:0] fp_wr_idx,
  input  logic [XLEN-1:0]  fp_wdata,
  input  logic [FIDXW:0]   fp_rd_idx,
  output logic [XLEN-1:0]  fp_rd_data,
  input  logic [DIDXW-1:0] dbg_idx,
  output logic [XLEN-1:0]  dbg_rdata
);
  logic int_bank_q, int_bank_d, fp_bank_q, fp_bank_d;

  brf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sr_we(sr_we), .sr_wdata(sr_wdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata),
    .fpscr_we(fpscr_we), .fpscr_wdata(fpscr_wdata),
    .sr_rdata(sr_rdata), .fpscr_rdata(fpscr_rdata),
    .int_bank_q(int_bank_q), .int_bank_d(int_bank_d),
    .fp_bank_q(fp_bank_q), .fp_bank_d(fp_bank_d)
  );

  brf_int_bank #(.XLEN(XLEN), .NGPR(NGPR), .NBANKED(NBANKED)) u_int (
    .clk(clk), .rst_n(rst_n),
    .bank_q(int_bank_q), .bank_d(int_bank_d),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .dbg_idx(dbg_idx), .dbg_rdata(dbg_rdata)
  );

  brf_fp_bank #(.XLEN(XLEN), .NFPR(NFPR)) u_fp (
    .clk(clk), .rst_n(rst_n),
    .bank_q(fp_bank_q), .bank_d(fp_bank_d),
    .fp_we(fp_we), .fp_wr_idx(fp_wr_idx), .fp_wdata(fp_wdata),
    .fp_rd_idx(fp_rd_idx), .fp_rd_data(fp_rd_data)
  );
endmodule

// File: rtl/brf_checker.sv
module brf_checker
  import brf_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NGPR    = 16,
  parameter int unsigned NBANKED = 8,
  localparam int unsigned IDXW   = $clog2(NGPR),
  localparam int unsigned DIDXW  = $clog2(NBANKED) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sr_we,
  input logic [31:0]      sr_wdata,
  input logic [31:0]      sr_rdata,
  input logic             flag_we,
  input logic [3:0]       flag_wdata,
  input logic             fpscr_we,
  input logic [31:0]      fpscr_wdata,
  input logic [31:0]      fpscr_rdata,
  input logic             wr_en,
  input logic [IDXW-1:0]  rd_a_idx,
  input logic [XLEN-1:0]  rd_a_data,
  input logic [DIDXW-1:0] dbg_idx,
  input logic [XLEN-1:0]  dbg_rdata,
  input logic             int_bank
);
  a_r4_sr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> sr_rdata == ($past(sr_wdata) & SR_WMASK));

  a_r6_fpc_masked: assert property (@(posedge clk) disable iff (!rst_n)
    fpscr_we |=> fpscr_rdata == ($past(fpscr_wdata) & FPC_WMASK));

  a_r3_swap_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && (sr_wdata[SR_MD_BIT] & sr_wdata[SR_RB_BIT]) != int_bank)
      |=> int_bank != $past(int_bank));

  a_r3_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_we |=> $stable(int_bank));

  a_r5_flag_port: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !sr_we) |=> (sr_rdata[SR_T_BIT] == $past(flag_wdata[0]))
                          && (sr_rdata[SR_M_BIT] == $past(flag_wdata[3])));

  a_r8_dbg_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (dbg_idx != $past(dbg_idx)) || (dbg_rdata == $past(dbg_rdata)));

  a_r2_shared_unbanked: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_a_idx >= IDXW'(NBANKED))
      |=> (rd_a_idx != $past(rd_a_idx)) || (rd_a_data == $past(rd_a_data)));
endmodule

bind bank_regfile brf_checker #(.XLEN(XLEN), .NGPR(NGPR), .NBANKED(NBANKED)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
  .flag_we(flag_we), .flag_wdata(flag_wdata),
  .fpscr_we(fpscr_we), .fpscr_wdata(fpscr_wdata), .fpscr_rdata(fpscr_rdata),
  .wr_en(wr_en), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .dbg_idx(dbg_idx), .dbg_rdata(dbg_rdata),
  .int_bank(int_bank_q)
);

// File: tb/bank_regfile_tb.sv
module bank_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, fp_wr_idx = '0, dbg_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, sr_rdata, fpscr_rdata, fp_rd_data, dbg_rdata;
  logic        wr_en = 1'b0, flag_we = 1'b0, sr_we = 1'b0, fpscr_we = 1'b0, fp_we = 1'b0;
  logic [31:0] wr_data = '0, sr_wdata = '0, fpscr_wdata = '0, fp_wdata = '0;
  logic [3:0]  flag_wdata = '0;
  logic [4:0]  fp_rd_idx = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model: live/shadow arrays that really trade contents
  logic [31:0] m_gpr [16];
  logic [31:0] m_shd [8];
  logic [31:0] m_fr [16];
  logic [31:0] m_xf [16];
  logic [31:0] m_sr;
  logic [3:0]  m_flg;
  logic [31:0] m_fpc;

  always #2.5 clk = ~clk;

  bank_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .flag_we(flag_we), .flag_wdata(flag_wdata),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .fpscr_we(fpscr_we), .fpscr_wdata(fpscr_wdata), .fpscr_rdata(fpscr_rdata),
    .fp_we(fp_we), .fp_wr_idx(fp_wr_idx), .fp_wdata(fp_wdata),
    .fp_rd_idx(fp_rd_idx), .fp_rd_data(fp_rd_data),
    .dbg_idx(dbg_idx), .dbg_rdata(dbg_rdata)
  );

  function automatic logic m_bank();
    return m_sr[30] & m_sr[29];
  endfunction

  function automatic logic [31:0] exp_sr();
    return m_sr | {22'd0, m_flg[3], m_flg[2], 6'd0, m_flg[1], m_flg[0]};
  endfunction

  function automatic logic [31:0] exp_gpr(input logic [3:0] i);
    return m_gpr[i];
  endfunction

  function automatic logic [31:0] exp_dbg(input logic [3:0] i);
    if (i[3] == m_bank()) return m_gpr[{1'b0, i[2:0]}];
    else                  return m_shd[i[2:0]];
  endfunction

  function automatic logic [31:0] exp_fp(input logic [4:0] i);
    return i[4] ? m_xf[i[3:0]] : m_fr[i[3:0]];
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 read A", rd_a_data, exp_gpr(rd_a_idx));
    chk("R2 read B", rd_b_data, exp_gpr(rd_b_idx));
    chk("R8 debug", dbg_rdata, exp_dbg(dbg_idx));
    chk("R7 fp read", fp_rd_data, exp_fp(fp_rd_idx));
    chk("R5 status read", sr_rdata, exp_sr());
    chk("R6 fp control", fpscr_rdata, m_fpc);
  endtask

  task automatic model_update();
    logic [31:0] nv;
    logic [31:0] tmp;
    if (sr_we) begin
      nv = sr_wdata & 32'h7000_83F3;
      if ((nv[30] & nv[29]) != m_bank())
        for (int i = 0; i < 8; i++) begin
          tmp = m_gpr[i]; m_gpr[i] = m_shd[i]; m_shd[i] = tmp;
        end
      m_sr  = nv & ~32'h0000_0303;
      m_flg = {sr_wdata[9], sr_wdata[8], sr_wdata[1], sr_wdata[0]};
    end else if (flag_we) begin
      m_flg = flag_wdata;
    end
    if (wr_en) m_gpr[wr_idx] = wr_data;
    if (fpscr_we) begin
      nv = fpscr_wdata & 32'h003F_FFFF;
      if (nv[21] != m_fpc[21])
        for (int i = 0; i < 16; i++) begin
          tmp = m_fr[i]; m_fr[i] = m_xf[i]; m_xf[i] = tmp;
        end
      m_fpc = nv;
    end
    if (fp_we) m_fr[fp_wr_idx] = fp_wdata;
  endtask

  // inputs already driven at a negedge; check, clock, model, back to negedge
  task automatic step();
    #1;
    check_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; sr_we = 0; flag_we = 0; fpscr_we = 0; fp_we = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin m_gpr[i] = '0; m_fr[i] = '0; m_xf[i] = '0; end
    for (int i = 0; i < 8; i++) m_shd[i] = '0;
    m_sr = 32'h7000_00F0; m_flg = '0; m_fpc = 32'h0004_0001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    #1;
    chk("R1 status reset", sr_rdata, 32'h7000_00F0);
    chk("R1 fp control reset", fpscr_rdata, 32'h0004_0001);
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); dbg_idx = 4'(i); fp_rd_idx = 5'(i * 2); #1;
      chk("R1 gpr zero", rd_a_data, 32'h0);
      chk("R1 debug zero", dbg_rdata, 32'h0);
      chk("R1 fp zero", fp_rd_data, 32'h0);
    end
    @(negedge clk);

    // R9: write R2 while switching to bank 0 (MD=1, RB=0)
    sr_we = 1; sr_wdata = 32'h4000_0000; wr_en = 1; wr_idx = 4'd2; wr_data = 32'hA5A5_0002;
    step(); idle();
    rd_a_idx = 4'd2; dbg_idx = 4'd2; #1;
    chk("R9 live after swap", rd_a_data, 32'hA5A5_0002);
    chk("R9 landed in bank0", dbg_rdata, 32'hA5A5_0002);
    dbg_idx = 4'd10; #1;
    chk("R9 bank1 untouched", dbg_rdata, 32'h0);
    @(negedge clk);

    // R3: MD=0, RB=1 keeps effective bank 0, no swap
    sr_we = 1; sr_wdata = 32'h2000_0000;
    step(); idle();
    rd_a_idx = 4'd2; #1;
    chk("R3 no swap same bank", rd_a_data, 32'hA5A5_0002);
    // R3: back to bank 1, R2 now reads the old (zero) copy
    sr_we = 1; sr_wdata = 32'h6000_0000;
    step(); idle();
    rd_a_idx = 4'd2; #1;
    chk("R3 swap on change", rd_a_data, 32'h0);
    @(negedge clk);

    // R4: mask on status write
    sr_we = 1; sr_wdata = 32'hFFFF_FFFF;
    step(); idle(); #1;
    chk("R4 status mask", sr_rdata, 32'h7000_83F3);
    // R5: status write wins over flag port
    sr_we = 1; sr_wdata = 32'h7000_0000; flag_we = 1; flag_wdata = 4'hF;
    step(); idle(); #1;
    chk("R5 status write priority", sr_rdata, 32'h7000_0000);
    flag_we = 1; flag_wdata = 4'b0101;
    step(); idle(); #1;
    chk("R5 flag merge", sr_rdata, 32'h7000_0101);
    @(negedge clk);

    // R6: FP write in the same cycle as a bank flip
    fp_we = 1; fp_wr_idx = 4'd3; fp_wdata = 32'h3F80_0003;
    step(); idle();
    fpscr_we = 1; fpscr_wdata = 32'h0024_0001; fp_we = 1; fp_wr_idx = 4'd3; fp_wdata = 32'h4000_0033;
    step(); idle();
    fp_rd_idx = 5'd3; #1;
    chk("R6 write lands post-flip", fp_rd_data, 32'h4000_0033);
    fp_rd_idx = 5'd19; #1;
    chk("R7 extended holds old", fp_rd_data, 32'h3F80_0003);
    fpscr_we = 1; fpscr_wdata = 32'hFFFF_FFFF;
    step(); idle();
    fp_rd_idx = 5'd3; #1;
    chk("R6 mask, no flip", fpscr_rdata, 32'h003F_FFFF);
    chk("R6 no flip kept", fp_rd_data, 32'h4000_0033);
    @(negedge clk);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      rd_a_idx    = 4'($urandom_range(15));
      rd_b_idx    = 4'($urandom_range(15));
      dbg_idx     = 4'($urandom_range(15));
      fp_rd_idx   = 5'($urandom_range(31));
      wr_en       = ($urandom_range(1) == 1);
      wr_idx      = 4'($urandom_range(15));
      wr_data     = $urandom;
      sr_we       = ($urandom_range(3) == 0);
      sr_wdata    = $urandom;
      flag_we     = ($urandom_range(3) == 0);
      flag_wdata  = 4'($urandom_range(15));
      fpscr_we    = ($urandom_range(5) == 0);
      fpscr_wdata = $urandom;
      fp_we       = ($urandom_range(1) == 1);
      fp_wr_idx   = 4'($urandom_range(15));
      fp_wdata    = $urandom;
      step();
    end
    idle();
    step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule